// File: doc/BRIEF.md
# Interrupt Request Tracker with Remote-IRR and EOI Redelivery

This block sits between a set of interrupt input lines and a delivery fabric. Each pin has a configuration entry supplied from outside: trigger type (edge or level), mask, vector and destination. The block keeps one request bit per pin and turns line level reports into delivery messages. Repeat assertions that cannot be delivered are reported as coalesced. Deliveries leave through a valid/ready handshake. The receiver returns an accepted flag with the handshake that says whether at least one target took the message.

Level-triggered pins are held off by a per-pin remote-IRR flag, which is set when a level delivery is accepted. A level-type end-of-interrupt (EOI) broadcast carrying a vector clears that flag on every level pin with the same vector. A pin whose line is still asserted and whose entry is unmasked is then queued for delivery again. Edge-triggered deliveries set a per-pin delivered bit, and a state snapshot output shows the request bits with the delivered bits removed. When several pins wait at once, the lowest-numbered unmasked pin is presented first, and only one delivery leaves per cycle.

Top module: `irq_req_tracker`

## Requirements
- R1: After reset, all request, pending, delivered and remote-IRR state is clear, so `dlv_valid`, `coal_o`, `fail_o`, `remote_irr` and `snap_irr` are all zero.
- R2: A strobe with `lvl_val` = 0 clears that pin's request bit. It raises neither the coalesced pulse nor the fail pulse.
- R3: A strobe with `lvl_val` = 1 on an edge pin (`cfg_level` bit = 0) whose request bit is already set raises bit i of `coal_o` in the following cycle and queues no delivery.
- R4: A strobe with `lvl_val` = 1 on a level pin (`cfg_level` bit = 1) is coalesced in the same way when its remote-IRR is set. This also holds when the pin's level delivery is accepted in that same cycle.
- R5: An assertion that is not coalesced and arrives on a masked pin raises bit i of `fail_o` in the following cycle and is dropped. A pin whose `cfg_mask` bit is 1 is never presented on the delivery port.
- R6: A handshake (`dlv_valid` and `dlv_ready`) for a level pin with `dlv_accepted` = 1 sets that pin's remote-IRR. With `dlv_accepted` = 0 the flag stays clear.
- R7: A handshake for an edge pin sets its delivered bit. A new assertion of that pin clears the bit. `snap_irr` equals the request bits with the delivered bits removed.
- R8: An EOI with `eoi_level` = 1 and `eoi_directed` = 0 clears remote-IRR on every level pin whose vector equals `eoi_vector`. Each such pin that had remote-IRR set, still has its request bit set after this cycle's strobes, and is unmasked is queued for delivery again.
- R9: An EOI with `eoi_level` = 0, or with `eoi_directed` = 1, leaves every remote-IRR flag unchanged.
- R10: The delivery port presents the lowest-numbered pending unmasked pin with its vector, destination and trigger type. It stays valid until the handshake unless the masks change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_stb | input | NPINS | Per-pin level report strobe |
| lvl_val | input | NPINS | Reported line level, used where `lvl_stb` is set |
| cfg_level | input | NPINS | Trigger type per pin: 1 level, 0 edge |
| cfg_mask | input | NPINS | Mask per pin: 1 masked |
| cfg_vector | input | NPINS*VEC_W | Vector per pin, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | NPINS*DEST_W | Destination per pin, pin i at bits [i*DEST_W +: DEST_W] |
| eoi_valid | input | 1 | EOI broadcast present this cycle |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| eoi_level | input | 1 | EOI is level-type |
| eoi_directed | input | 1 | Directed-EOI mode, which makes the broadcast ineffective |
| dlv_ready | input | 1 | Receiver takes the presented delivery |
| dlv_accepted | input | 1 | At least one target accepted it; valid with the handshake |
| dlv_valid | output | 1 | A delivery is presented |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_vector | output | VEC_W | Vector of the delivery |
| dlv_dest | output | DEST_W | Destination of the delivery |
| dlv_level | output | 1 | Trigger type of the delivery |
| coal_o | output | NPINS | One-cycle pulse per pin: assertion coalesced |
| fail_o | output | NPINS | One-cycle pulse per pin: service refused by mask |
| remote_irr | output | NPINS | Remote-IRR flags |
| snap_irr | output | NPINS | Request bits with delivered bits removed |

## Verification
The bench builds the block with four pins, 8-bit vectors and 4-bit destinations. With that size, two level pins can share a vector, so one EOI clears both, while one edge pin stays unmasked and another is masked. Four pins are few enough that random strobes often make several pins pending together, which exercises the lowest-first order and collisions between a handshake, an EOI and a strobe in the same cycle. Halfway through, one pin is switched from edge to level so that a third pin also answers the shared vector.

// File: rtl/irq_req_tracker.sv
module irq_req_tracker #(
  parameter int NPINS  = 24,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPINS-1:0]        lvl_stb,
  input  logic [NPINS-1:0]        lvl_val,
  input  logic [NPINS-1:0]        cfg_level,
  input  logic [NPINS-1:0]        cfg_mask,
  input  logic [NPINS*VEC_W-1:0]  cfg_vector,
  input  logic [NPINS*DEST_W-1:0] cfg_dest,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vector,
  input  logic                    eoi_level,
  input  logic                    eoi_directed,
  input  logic                    dlv_ready,
  input  logic                    dlv_accepted,
  output logic                    dlv_valid,
  output logic [PIN_W-1:0]        dlv_pin,
  output logic [VEC_W-1:0]        dlv_vector,
  output logic [DEST_W-1:0]       dlv_dest,
  output logic                    dlv_level,
  output logic [NPINS-1:0]        coal_o,
  output logic [NPINS-1:0]        fail_o,
  output logic [NPINS-1:0]        remote_irr,
  output logic [NPINS-1:0]        snap_irr
);

  logic [NPINS-1:0] irr, pend, dlvd, rirr;
  logic [NPINS-1:0] eoi_hit, cand, sel;
  logic             fire;

  wire [NPINS-1:0] asrt = lvl_stb & lvl_val;
  wire [NPINS-1:0] deas = lvl_stb & ~lvl_val;
  wire [NPINS-1:0] irr_n = (irr | asrt) & ~deas;
  wire             eoi_ok = eoi_valid & eoi_level & ~eoi_directed;

  always_comb begin
    for (int i = 0; i < NPINS; i++)
      eoi_hit[i] = eoi_ok & cfg_level[i] & (cfg_vector[i*VEC_W +: VEC_W] == eoi_vector);
  end

  assign cand = pend & ~cfg_mask;

  always_comb begin
    dlv_pin   = '0;
    dlv_valid = 1'b0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        dlv_pin   = PIN_W'(i);
        dlv_valid = 1'b1;
      end
    end
  end

  assign dlv_vector = cfg_vector[dlv_pin*VEC_W +: VEC_W];
  assign dlv_dest   = cfg_dest[dlv_pin*DEST_W +: DEST_W];
  assign dlv_level  = cfg_level[dlv_pin];
  assign fire       = dlv_valid & dlv_ready;
  assign sel        = fire ? (NPINS'(1) << dlv_pin) : '0;

  wire [NPINS-1:0] acc_set = sel & cfg_level & {NPINS{dlv_accepted}};
  wire [NPINS-1:0] blocked = (rirr & ~eoi_hit) | acc_set;
  wire [NPINS-1:0] coal_n  = asrt & ((~cfg_level & irr) | (cfg_level & blocked));
  wire [NPINS-1:0] svc     = asrt & ~coal_n;
  wire [NPINS-1:0] redo    = eoi_hit & rirr & irr_n;
  wire [NPINS-1:0] add     = (svc | redo) & ~cfg_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr    <= '0;
      pend   <= '0;
      dlvd   <= '0;
      rirr   <= '0;
      coal_o <= '0;
      fail_o <= '0;
    end else begin
      irr    <= irr_n;
      pend   <= (pend & ~sel) | add;
      dlvd   <= (dlvd | (sel & ~cfg_level)) & ~(asrt & ~cfg_level);
      rirr   <= blocked;
      coal_o <= coal_n;
      fail_o <= svc & cfg_mask;
    end
  end

  assign remote_irr = rirr;
  assign snap_irr   = irr & ~dlvd;

endmodule

// File: rtl/irq_req_tracker_chk.sv
module irq_req_tracker_chk #(
  parameter int NPINS = 24,
  parameter int PIN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] lvl_stb,
  input logic [NPINS-1:0] lvl_val,
  input logic [NPINS-1:0] cfg_level,
  input logic [NPINS-1:0] cfg_mask,
  input logic             eoi_valid,
  input logic             eoi_level,
  input logic             eoi_directed,
  input logic             dlv_ready,
  input logic             dlv_valid,
  input logic [PIN_W-1:0] dlv_pin,
  input logic [NPINS-1:0] coal_o,
  input logic [NPINS-1:0] fail_o,
  input logic [NPINS-1:0] remote_irr,
  input logic [NPINS-1:0] snap_irr,
  input logic [NPINS-1:0] pend
);

  a_r5_masked_never_presented: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !cfg_mask[dlv_pin]);

  a_r10_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid || !$stable(cfg_mask)));

  a_r9_ineffective_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && (!eoi_level || eoi_directed) && !(dlv_valid && dlv_ready))
      |=> $stable(remote_irr));

  a_r4_level_not_double_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_irr & pend & cfg_level) == '0);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r2_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_stb[i] && !lvl_val[i]) |=> (!snap_irr[i] && !coal_o[i] && !fail_o[i]));

    a_r3_edge_repeat_coalesced: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_level[i] && lvl_stb[i] && lvl_val[i] && snap_irr[i]) |=> coal_o[i]);

    a_r4_level_blocked_coalesced: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_level[i] && lvl_stb[i] && lvl_val[i] && remote_irr[i] && !eoi_valid) |=> coal_o[i]);
  end

endmodule

bind irq_req_tracker irq_req_tracker_chk #(.NPINS(NPINS), .PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl_stb(lvl_stb), .lvl_val(lvl_val),
  .cfg_level(cfg_level), .cfg_mask(cfg_mask), .eoi_valid(eoi_valid),
  .eoi_level(eoi_level), .eoi_directed(eoi_directed), .dlv_ready(dlv_ready),
  .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .coal_o(coal_o), .fail_o(fail_o),
  .remote_irr(remote_irr), .snap_irr(snap_irr), .pend(pend)
);

// File: tb/irq_req_tracker_bench.sv
module irq_req_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int VW = 8;
  localparam int DW = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] lvl_stb = '0, lvl_val = '0, cfg_level = '0, cfg_mask = '0;
  logic [NP*VW-1:0] cfg_vector = '0;
  logic [NP*DW-1:0] cfg_dest = '0;
  logic eoi_valid = 1'b0, eoi_level = 1'b0, eoi_directed = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic dlv_ready = 1'b0, dlv_accepted = 1'b0;
  logic dlv_valid, dlv_level;
  logic [PW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic [DW-1:0] dlv_dest;
  logic [NP-1:0] coal_o, fail_o, remote_irr, snap_irr;

  irq_req_tracker #(.NPINS(NP), .VEC_W(VW), .DEST_W(DW)) u_irq_req_tracker (
    .clk(clk), .rst_n(rst_n), .lvl_stb(lvl_stb), .lvl_val(lvl_val),
    .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_vector(cfg_vector),
    .cfg_dest(cfg_dest), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .eoi_directed(eoi_directed), .dlv_ready(dlv_ready),
    .dlv_accepted(dlv_accepted), .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_level(dlv_level),
    .coal_o(coal_o), .fail_o(fail_o), .remote_irr(remote_irr), .snap_irr(snap_irr));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // Behavioural reference state
  bit m_irr[NP], m_pend[NP], m_dlvd[NP], m_rem[NP], m_coal[NP], m_fail[NP];

  function automatic int pick_pin();
    for (int i = 0; i < NP; i++) if (m_pend[i] && !cfg_mask[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        m_irr[i] = 0; m_pend[i] = 0; m_dlvd[i] = 0; m_rem[i] = 0; m_coal[i] = 0; m_fail[i] = 0;
      end
    end else begin
      int p;
      bit taken;
      p = pick_pin();
      taken = (p >= 0) && dlv_ready;
      for (int i = 0; i < NP; i++) begin
        bit up, down, lvl, hit, blk, nirr, add, was_rem;
        up = lvl_stb[i] && lvl_val[i];
        down = lvl_stb[i] && !lvl_val[i];
        lvl = cfg_level[i];
        hit = eoi_valid && eoi_level && !eoi_directed && lvl && (cfg_vector[i*VW +: VW] == eoi_vector);
        was_rem = m_rem[i];
        blk = (m_rem[i] && !hit) || (taken && p == i && lvl && dlv_accepted);
        nirr = down ? 0 : (up ? 1 : m_irr[i]);
        m_coal[i] = 0; m_fail[i] = 0; add = 0;
        if (up) begin
          if (lvl ? blk : m_irr[i]) m_coal[i] = 1;
          else if (cfg_mask[i]) m_fail[i] = 1;
          else add = 1;
        end
        if (hit && was_rem && nirr && !cfg_mask[i]) add = 1;
        if (taken && p == i && !lvl) m_dlvd[i] = 1;
        if (up && !lvl) m_dlvd[i] = 0;
        if (taken && p == i) m_pend[i] = 0;
        if (add) m_pend[i] = 1;
        m_rem[i] = blk;
        m_irr[i] = nirr;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int p;
    logic [NP-1:0] ec, ef, er, es;
    p = pick_pin();
    for (int i = 0; i < NP; i++) begin
      ec[i] = m_coal[i]; ef[i] = m_fail[i]; er[i] = m_rem[i]; es[i] = m_irr[i] && !m_dlvd[i];
    end
    chk(dlv_valid == (p >= 0), "R10 dlv_valid", dlv_valid, p >= 0);
    if (p >= 0) begin
      chk(dlv_pin == PW'(p), "R10 lowest pending pin", dlv_pin, p);
      chk(dlv_vector == cfg_vector[p*VW +: VW] && dlv_dest == cfg_dest[p*DW +: DW]
          && dlv_level == cfg_level[p], "R10 delivery fields", {dlv_level, dlv_dest, dlv_vector},
          {cfg_level[p], cfg_dest[p*DW +: DW], cfg_vector[p*VW +: VW]});
    end
    chk(coal_o == ec, "R3/R4 coalesced pulses", coal_o, ec);
    chk(fail_o == ef, "R5 mask fail pulses", fail_o, ef);
    chk(remote_irr == er, "R6/R8/R9 remote_irr", remote_irr, er);
    chk(snap_irr == es, "R2/R7 snapshot", snap_irr, es);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    lvl_stb = '0;
    eoi_valid = 1'b0;
  endtask

  task automatic strobe(input logic [NP-1:0] s, input logic [NP-1:0] v);
    lvl_stb = s; lvl_val = v;
    tick();
  endtask

  task automatic eoi(input logic [VW-1:0] vec, input bit lv, input bit dir);
    eoi_valid = 1'b1; eoi_vector = vec; eoi_level = lv; eoi_directed = dir;
    tick();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected<50000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    cfg_level = 4'b0011;
    cfg_mask = 4'b1000;
    cfg_vector = {8'h62, 8'h51, 8'h40, 8'h40};
    cfg_dest = {4'h4, 4'h3, 4'h2, 4'h1};
    dlv_ready = 1'b0; dlv_accepted = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1: idle after reset
    chk(!dlv_valid && coal_o == 0 && fail_o == 0 && remote_irr == 0 && snap_irr == 0,
        "R1 reset state", {dlv_valid, remote_irr, snap_irr}, 0);
    // three pins at once, receiver stalled: R10 hold and order
    strobe(4'b0111, 4'b0111);
    tick(); tick();
    chk(dlv_valid && dlv_pin == 0, "R10 held lowest pin", dlv_pin, 0);
    dlv_ready = 1'b1;
    tick(); tick(); tick();
    chk(remote_irr == 4'b0011, "R6 level pins flagged", remote_irr, 3);
    strobe(4'b1000, 4'b1000);                 // R5 masked pin
    chk(fail_o == 4'b1000, "R5 fail pulse", fail_o, 8);
    strobe(4'b0001, 4'b0001);                 // R4 level repeat
    chk(coal_o == 4'b0001, "R4 coalesced", coal_o, 1);
    strobe(4'b0100, 4'b0100);                 // R3 edge repeat
    chk(coal_o == 4'b0100, "R3 coalesced", coal_o, 4);
    strobe(4'b0010, 4'b0000);                 // R2 pin1 low
    eoi(8'h40, 1'b0, 1'b0);                   // R9 edge-type EOI
    chk(remote_irr == 4'b0011, "R9 edge EOI ignored", remote_irr, 3);
    eoi(8'h40, 1'b1, 1'b1);                   // R9 directed EOI
    chk(remote_irr == 4'b0011, "R9 directed EOI ignored", remote_irr, 3);
    dlv_accepted = 1'b0;
    eoi(8'h40, 1'b1, 1'b0);                   // R8 redeliver pin0 only
    chk(dlv_valid && dlv_pin == 0 && remote_irr == 0, "R8 EOI redelivery", remote_irr, 0);
    tick();
    chk(remote_irr == 0, "R6 not accepted keeps flag clear", remote_irr, 0);
    dlv_accepted = 1'b1;
    for (int n = 0; n < 4000; n++) begin
      logic [NP-1:0] s;
      s = NP'($urandom) & NP'($urandom);
      lvl_stb = s;
      lvl_val = NP'($urandom) | NP'($urandom);
      dlv_ready = ($urandom % 4) != 0;
      dlv_accepted = ($urandom % 4) != 0;
      if ($urandom % 6 == 0) begin
        eoi_valid = 1'b1;
        case ($urandom % 4)
          0: eoi_vector = 8'h40;
          1: eoi_vector = 8'h51;
          2: eoi_vector = 8'h62;
          default: eoi_vector = 8'h33;
        endcase
        eoi_level = ($urandom % 4) != 0;
        eoi_directed = ($urandom % 8) == 0;
      end
      if (n % 150 == 0) cfg_mask = NP'($urandom) & NP'($urandom);
      if (n == 2000) begin
        cfg_level[3] = 1'b1;
        cfg_vector[3*VW +: VW] = 8'h40;
      end
      tick();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule